// File: doc/BRIEF.md
# Lifetime-Based Dead Line Predictor

This block watches a small cache through three event streams: fills, accesses and evictions. Each event names a frame and, for fills, the line address. For every resident line the block counts the clock cycles since the fill. When the line leaves the cache, the block stores the line's lifetime in a small history table kept beside the correlation metadata and indexed by line address. The lifetime runs from the fill to the last access before the eviction.

When the same address is filled again, its earlier lifetime is loaded into the frame. Once the cycles spent in the cache exceed a safety multiple of that earlier lifetime, the line is judged dead. The block then emits a one-cycle trigger that carries the frame and the line address. A prefetcher can use the trigger as the earliest point to place a predicted successor into that frame.

Only one frame is checked per cycle, in rotating order. A line that is accessed after being judged dead counts as a wrong guess, and the block keeps a running count of such guesses.

Top module: `dbt_dead_trigger`

## Requirements
- R1: After reset, `dead_valid` is low and `mispredict_count` is zero.
- R2: The recorded lifetime is the line's age at its last access, where age counts clock edges after the fill edge. A line that is never accessed records 0. The lifetime is written on eviction to a history entry chosen by the low log2(HIST_DEPTH) bits of the line address, tagged with the remaining bits. A later fill of the same address, into any frame, loads it.
- R3: A line filled with a known lifetime L is never reported before its age exceeds 2·L. The trigger therefore appears no earlier than the sample after the (2L+2)-th clock edge following the fill edge.
- R4: A line whose address has no matching history entry never triggers. This covers an address never evicted and an address whose index entry holds a different tag.
- R5: Each residency produces at most one trigger. A new fill of the frame re-arms it, even for the same address.
- R6: A trigger is a single-cycle `dead_valid` pulse, with `dead_frame` and `dead_addr` naming the frame and its resident line address.
- R7: An access to a frame whose line has been reported dead increments `mispredict_count` by one and clears the dead mark. A second access to that frame leaves the count unchanged.
- R8: An access to a live, not yet reported line does not change `mispredict_count`.
- R9: A line evicted before its deadline is never reported.
- R10: Frames are examined one per cycle in rotating order, so a dead line is reported within NUM_FRAMES cycles of its deadline. Several lines that die together are each reported once, in separate cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fill_valid | input | 1 | A line is installed this cycle |
| fill_frame | input | FRAME_W | Frame receiving the line |
| fill_addr | input | ADDR_W | Line address being installed |
| access_valid | input | 1 | A resident line is hit this cycle |
| access_frame | input | FRAME_W | Frame being accessed |
| evict_valid | input | 1 | A line leaves the cache this cycle |
| evict_frame | input | FRAME_W | Frame being vacated |
| dead_valid | output | 1 | One-cycle dead-line trigger |
| dead_frame | output | FRAME_W | Frame judged dead |
| dead_addr | output | ADDR_W | Address of the line judged dead |
| mispredict_count | output | MISS_W | Saturating count of accesses to lines reported dead |

## Verification
A corrupted age or stored lifetime shows up as a trigger outside its window of 2L+2 to 2L+1+NUM_FRAMES cycles after the fill. It can also show up as a missing trigger, a trigger for an address with no history, or a second pulse in the same residency. A wrong dead mark appears on `mispredict_count` at the first access after the trigger, one cycle after that access. A stale phase left by an eviction appears as a pulse naming an empty frame within one scan round.

// File: rtl/dbt_pkg.sv
package dbt_pkg;
   localparam int unsigned DBT_FRAMES_DEF = 16;
   localparam int unsigned DBT_LIFE_W_DEF = 16;

   // Life cycle of one frame between fill and eviction
   typedef enum logic [2:0] {
      PH_EMPTY     = 3'd0,  // no line resident
      PH_UNTRACKED = 3'd1,  // resident, no earlier lifetime known
      PH_ARMED     = 3'd2,  // resident, waiting for its deadline
      PH_DEAD      = 3'd3,  // reported dead, not touched since
      PH_SPENT     = 3'd4   // reported, then touched again
   } phase_e;
endpackage

// File: rtl/dbt_life_hist.sv
module dbt_life_hist #(
   parameter int unsigned ADDR_W     = 26,
   parameter int unsigned LIFE_W     = 16,
   parameter int unsigned HIST_DEPTH = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [LIFE_W-1:0] wr_life,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              rd_known,
   output logic [LIFE_W-1:0] rd_life
);
   localparam int unsigned IDX_W = $clog2(HIST_DEPTH);
   localparam int unsigned TAG_W = ADDR_W - IDX_W;

   logic [IDX_W-1:0] wr_idx, rd_idx;
   logic [TAG_W-1:0] wr_tag, rd_tag;

   assign wr_idx = wr_addr[IDX_W-1:0];
   assign wr_tag = wr_addr[ADDR_W-1:IDX_W];
   assign rd_idx = rd_addr[IDX_W-1:0];
   assign rd_tag = rd_addr[ADDR_W-1:IDX_W];

   logic              vld_a  [HIST_DEPTH];
   logic [TAG_W-1:0]  tag_a  [HIST_DEPTH];
   logic [LIFE_W-1:0] life_a [HIST_DEPTH];

   for (genvar e = 0; e < HIST_DEPTH; e++) begin : g_entry
      logic              vld_q;
      logic [TAG_W-1:0]  tag_q;
      logic [LIFE_W-1:0] life_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld_q  <= 1'b0;
            tag_q  <= '0;
            life_q <= '0;
         end else if (wr_en && (wr_idx == IDX_W'(e))) begin
            vld_q  <= 1'b1;
            tag_q  <= wr_tag;
            life_q <= wr_life;
         end
      end

      assign vld_a[e]  = vld_q;
      assign tag_a[e]  = tag_q;
      assign life_a[e] = life_q;
   end

   assign rd_known = vld_a[rd_idx] && (tag_a[rd_idx] == rd_tag);
   assign rd_life  = life_a[rd_idx];
endmodule

// File: rtl/dbt_frame_bank.sv
module dbt_frame_bank import dbt_pkg::*; #(
   parameter int unsigned NUM_FRAMES = 16,
   parameter int unsigned FRAME_W    = 4,
   parameter int unsigned ADDR_W     = 26,
   parameter int unsigned LIFE_W     = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fill_valid,
   input  logic [FRAME_W-1:0] fill_frame,
   input  logic [ADDR_W-1:0]  fill_addr,
   input  logic               fill_known,
   input  logic [LIFE_W-1:0]  fill_prev,
   input  logic               access_valid,
   input  logic [FRAME_W-1:0] access_frame,
   input  logic               evict_valid,
   input  logic [FRAME_W-1:0] evict_frame,
   input  logic               fire,
   input  logic [FRAME_W-1:0] fire_frame,
   output phase_e             phase_o [NUM_FRAMES],
   output logic [ADDR_W-1:0]  addr_o  [NUM_FRAMES],
   output logic [LIFE_W-1:0]  age_o   [NUM_FRAMES],
   output logic [LIFE_W-1:0]  last_o  [NUM_FRAMES],
   output logic [LIFE_W-1:0]  prev_o  [NUM_FRAMES]
);
   for (genvar f = 0; f < NUM_FRAMES; f++) begin : g_frame
      logic hit_fill, hit_evict, hit_access, hit_fire;
      phase_e            phase_q;
      logic [ADDR_W-1:0] addr_q;
      logic [LIFE_W-1:0] age_q, last_q, prev_q;

      assign hit_fill   = fill_valid   && (fill_frame   == FRAME_W'(f));
      assign hit_evict  = evict_valid  && (evict_frame  == FRAME_W'(f));
      assign hit_access = access_valid && (access_frame == FRAME_W'(f));
      assign hit_fire   = fire         && (fire_frame   == FRAME_W'(f));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            phase_q <= PH_EMPTY;
            addr_q  <= '0;
            age_q   <= '0;
            last_q  <= '0;
            prev_q  <= '0;
         end else if (hit_fill) begin
            phase_q <= fill_known ? PH_ARMED : PH_UNTRACKED;
            addr_q  <= fill_addr;
            age_q   <= '0;
            last_q  <= '0;
            prev_q  <= fill_prev;
         end else if (hit_evict) begin
            phase_q <= PH_EMPTY;
         end else if (phase_q != PH_EMPTY) begin
            if (age_q != '1) begin
               age_q <= age_q + 1'b1;
            end
            if (hit_access) begin
               last_q <= age_q;
               if (phase_q == PH_DEAD) begin
                  phase_q <= PH_SPENT;
               end
            end else if (hit_fire) begin
               phase_q <= PH_DEAD;
            end
         end
      end

      assign phase_o[f] = phase_q;
      assign addr_o[f]  = addr_q;
      assign age_o[f]   = age_q;
      assign last_o[f]  = last_q;
      assign prev_o[f]  = prev_q;
   end
endmodule

// File: rtl/dbt_scan.sv
module dbt_scan import dbt_pkg::*; #(
   parameter int unsigned NUM_FRAMES   = 16,
   parameter int unsigned FRAME_W      = 4,
   parameter int unsigned LIFE_W       = 16,
   parameter int unsigned SAFETY_SHIFT = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  phase_e             phase_i [NUM_FRAMES],
   input  logic [LIFE_W-1:0]  age_i   [NUM_FRAMES],
   input  logic [LIFE_W-1:0]  prev_i  [NUM_FRAMES],
   input  logic               fill_valid,
   input  logic [FRAME_W-1:0] fill_frame,
   input  logic               access_valid,
   input  logic [FRAME_W-1:0] access_frame,
   input  logic               evict_valid,
   input  logic [FRAME_W-1:0] evict_frame,
   output logic [FRAME_W-1:0] ptr_o,
   output logic               fire_o
);
   localparam int unsigned CMP_W = LIFE_W + SAFETY_SHIFT;

   logic [FRAME_W-1:0] ptr_q;
   logic [CMP_W-1:0]   age_ext, limit;
   logic               busy, past_due;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (ptr_q == FRAME_W'(NUM_FRAMES - 1)) begin
         ptr_q <= '0;
      end else begin
         ptr_q <= ptr_q + 1'b1;
      end
   end

   assign age_ext = CMP_W'(age_i[ptr_q]);

   if (SAFETY_SHIFT == 0) begin : g_unscaled
      assign limit = prev_i[ptr_q];
   end else begin : g_scaled
      assign limit = {prev_i[ptr_q], {SAFETY_SHIFT{1'b0}}};
   end

   // Any event on the scanned frame this cycle defers the decision one round
   assign busy = (fill_valid   && (fill_frame   == ptr_q)) ||
                 (evict_valid  && (evict_frame  == ptr_q)) ||
                 (access_valid && (access_frame == ptr_q));

   assign past_due = age_ext > limit;
   assign fire_o   = (phase_i[ptr_q] == PH_ARMED) && past_due && !busy;
   assign ptr_o    = ptr_q;
endmodule

// File: rtl/dbt_dead_trigger.sv
module dbt_dead_trigger import dbt_pkg::*; #(
   parameter int unsigned NUM_FRAMES   = DBT_FRAMES_DEF,
   parameter int unsigned ADDR_W       = 26,
   parameter int unsigned LIFE_W       = DBT_LIFE_W_DEF,
   parameter int unsigned HIST_DEPTH   = 32,
   parameter int unsigned SAFETY_SHIFT = 1,
   parameter int unsigned MISS_W       = 16,
   localparam int unsigned FRAME_W     = $clog2(NUM_FRAMES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fill_valid,
   input  logic [FRAME_W-1:0] fill_frame,
   input  logic [ADDR_W-1:0]  fill_addr,
   input  logic               access_valid,
   input  logic [FRAME_W-1:0] access_frame,
   input  logic               evict_valid,
   input  logic [FRAME_W-1:0] evict_frame,
   output logic               dead_valid,
   output logic [FRAME_W-1:0] dead_frame,
   output logic [ADDR_W-1:0]  dead_addr,
   output logic [MISS_W-1:0]  mispredict_count
);
   if (NUM_FRAMES < 2) begin : g_bad_frames
      $error("dbt_dead_trigger: NUM_FRAMES must be at least 2");
   end
   if ((HIST_DEPTH < 2) || ((HIST_DEPTH & (HIST_DEPTH - 1)) != 0)) begin : g_bad_hist
      $error("dbt_dead_trigger: HIST_DEPTH must be a power of two, at least 2");
   end
   if (ADDR_W <= $clog2(HIST_DEPTH)) begin : g_bad_addr
      $error("dbt_dead_trigger: ADDR_W must exceed the history index width");
   end
   if ((SAFETY_SHIFT > 4) || (LIFE_W < 2) || (MISS_W < 1)) begin : g_bad_width
      $error("dbt_dead_trigger: unsupported counter or margin configuration");
   end

   phase_e            phase_a [NUM_FRAMES];
   logic [ADDR_W-1:0] addr_a  [NUM_FRAMES];
   logic [LIFE_W-1:0] age_a   [NUM_FRAMES];
   logic [LIFE_W-1:0] last_a  [NUM_FRAMES];
   logic [LIFE_W-1:0] prev_a  [NUM_FRAMES];

   logic               hist_known, hist_wr, same_ae, same_fa, same_ea;
   logic [LIFE_W-1:0]  hist_life, leave_life;
   logic [FRAME_W-1:0] scan_ptr;
   logic               fire, wrong_guess;

   // Lifetime recorded on departure; an access in the same cycle is the last one
   assign same_ae    = access_valid && (access_frame == evict_frame);
   assign hist_wr    = evict_valid && (phase_a[evict_frame] != PH_EMPTY);
   assign leave_life = same_ae ? age_a[evict_frame] : last_a[evict_frame];

   dbt_life_hist #(
      .ADDR_W     (ADDR_W),
      .LIFE_W     (LIFE_W),
      .HIST_DEPTH (HIST_DEPTH)
   ) u_hist (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (hist_wr),
      .wr_addr  (addr_a[evict_frame]),
      .wr_life  (leave_life),
      .rd_addr  (fill_addr),
      .rd_known (hist_known),
      .rd_life  (hist_life)
   );

   dbt_frame_bank #(
      .NUM_FRAMES (NUM_FRAMES),
      .FRAME_W    (FRAME_W),
      .ADDR_W     (ADDR_W),
      .LIFE_W     (LIFE_W)
   ) u_bank (
      .clk          (clk),
      .rst_n        (rst_n),
      .fill_valid   (fill_valid),
      .fill_frame   (fill_frame),
      .fill_addr    (fill_addr),
      .fill_known   (hist_known),
      .fill_prev    (hist_life),
      .access_valid (access_valid),
      .access_frame (access_frame),
      .evict_valid  (evict_valid),
      .evict_frame  (evict_frame),
      .fire         (fire),
      .fire_frame   (scan_ptr),
      .phase_o      (phase_a),
      .addr_o       (addr_a),
      .age_o        (age_a),
      .last_o       (last_a),
      .prev_o       (prev_a)
   );

   dbt_scan #(
      .NUM_FRAMES   (NUM_FRAMES),
      .FRAME_W      (FRAME_W),
      .LIFE_W       (LIFE_W),
      .SAFETY_SHIFT (SAFETY_SHIFT)
   ) u_scan (
      .clk          (clk),
      .rst_n        (rst_n),
      .phase_i      (phase_a),
      .age_i        (age_a),
      .prev_i       (prev_a),
      .fill_valid   (fill_valid),
      .fill_frame   (fill_frame),
      .access_valid (access_valid),
      .access_frame (access_frame),
      .evict_valid  (evict_valid),
      .evict_frame  (evict_frame),
      .ptr_o        (scan_ptr),
      .fire_o       (fire)
   );

   assign same_fa     = fill_valid  && (fill_frame  == access_frame);
   assign same_ea     = evict_valid && (evict_frame == access_frame);
   assign wrong_guess = access_valid && (phase_a[access_frame] == PH_DEAD) &&
                        !same_fa && !same_ea;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dead_valid       <= 1'b0;
         dead_frame       <= '0;
         dead_addr        <= '0;
         mispredict_count <= '0;
      end else begin
         dead_valid <= fire;
         if (fire) begin
            dead_frame <= scan_ptr;
            dead_addr  <= addr_a[scan_ptr];
         end
         if (wrong_guess && (mispredict_count != '1)) begin
            mispredict_count <= mispredict_count + 1'b1;
         end
      end
   end
endmodule

// File: rtl/dbt_dead_trigger_chk.sv
module dbt_dead_trigger_chk #(
   parameter int unsigned NUM_FRAMES = 16,
   parameter int unsigned FRAME_W    = 4,
   parameter int unsigned MISS_W     = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               fill_valid,
   input logic [FRAME_W-1:0] fill_frame,
   input logic               access_valid,
   input logic               evict_valid,
   input logic [FRAME_W-1:0] evict_frame,
   input logic               dead_valid,
   input logic [FRAME_W-1:0] dead_frame,
   input logic [MISS_W-1:0]  mispredict_count
);
   logic [NUM_FRAMES-1:0] resident_q, reported_q;

   // Shadow of residency and of triggers seen, built from the ports only
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         resident_q <= '0;
         reported_q <= '0;
      end else begin
         for (int f = 0; f < NUM_FRAMES; f++) begin
            if (fill_valid && (fill_frame == FRAME_W'(f))) begin
               resident_q[f] <= 1'b1;
               reported_q[f] <= 1'b0;
            end else begin
               if (evict_valid && (evict_frame == FRAME_W'(f))) begin
                  resident_q[f] <= 1'b0;
               end
               if (dead_valid && (dead_frame == FRAME_W'(f))) begin
                  reported_q[f] <= 1'b1;
               end
            end
         end
      end
   end

   p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> !dead_valid)
      else $error("trigger raised out of reset");

   p_single_shot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      dead_valid |-> !reported_q[dead_frame])
      else $error("second trigger in one residency");

   p_resident_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
      dead_valid |-> resident_q[dead_frame])
      else $error("trigger for an empty frame");

   p_miss_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mispredict_count == $past(mispredict_count)) ||
      (mispredict_count == $past(mispredict_count) + 1'b1))
      else $error("wrong-guess count jumped");

   p_miss_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mispredict_count != $past(mispredict_count)) |-> $past(access_valid))
      else $error("wrong-guess count moved without an access");
endmodule

bind dbt_dead_trigger dbt_dead_trigger_chk #(
   .NUM_FRAMES (NUM_FRAMES),
   .FRAME_W    (FRAME_W),
   .MISS_W     (MISS_W)
) i_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .fill_valid       (fill_valid),
   .fill_frame       (fill_frame),
   .access_valid     (access_valid),
   .evict_valid      (evict_valid),
   .evict_frame      (evict_frame),
   .dead_valid       (dead_valid),
   .dead_frame       (dead_frame),
   .mispredict_count (mispredict_count)
);

// File: tb/test_dbt_dead_trigger.sv
module test_dbt_dead_trigger;
   localparam int NF  = 16;
   localparam int FW  = 4;
   localparam int AW  = 26;
   localparam int MW  = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          fill_valid = 1'b0, access_valid = 1'b0, evict_valid = 1'b0;
   logic [FW-1:0] fill_frame = '0, access_frame = '0, evict_frame = '0;
   logic [AW-1:0] fill_addr = '0;
   logic          dead_valid;
   logic [FW-1:0] dead_frame;
   logic [AW-1:0] dead_addr;
   logic [MW-1:0] mispredict_count;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // triggers captured by watch()
   int trig_cnt;
   int trig_n [8];
   int trig_f [8];
   int trig_a [8];

   always #5 clk = ~clk;

   dbt_dead_trigger i_dbt_dead_trigger (
      .clk              (clk),
      .rst_n            (rst_n),
      .fill_valid       (fill_valid),
      .fill_frame       (fill_frame),
      .fill_addr        (fill_addr),
      .access_valid     (access_valid),
      .access_frame     (access_frame),
      .evict_valid      (evict_valid),
      .evict_frame      (evict_frame),
      .dead_valid       (dead_valid),
      .dead_frame       (dead_frame),
      .dead_addr        (dead_addr),
      .mispredict_count (mispredict_count)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // All drivers start and end at a falling edge
   task automatic do_fill(input int f, input int a);
      fill_valid = 1'b1; fill_frame = FW'(f); fill_addr = AW'(a);
      @(negedge clk);
      fill_valid = 1'b0;
   endtask

   task automatic do_access(input int f);
      access_valid = 1'b1; access_frame = FW'(f);
      @(negedge clk);
      access_valid = 1'b0;
   endtask

   task automatic do_evict(input int f);
      evict_valid = 1'b1; evict_frame = FW'(f);
      @(negedge clk);
      evict_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic watch(input int n);
      trig_cnt = 0;
      for (int i = 1; i <= n; i++) begin
         @(negedge clk);
         if (dead_valid) begin
            if (trig_cnt < 8) begin
               trig_n[trig_cnt] = i;
               trig_f[trig_cnt] = int'(dead_frame);
               trig_a[trig_cnt] = int'(dead_addr);
            end
            trig_cnt++;
         end
      end
   endtask

   // lifetime L is taught by: fill, idle(L), access, evict
   task automatic teach(input int f, input int a, input int life);
      do_fill(f, a);
      idle(life);
      do_access(f);
      do_evict(f);
   endtask

   task automatic t_reset;
      check(dead_valid == 1'b0, "R1", "dead_valid after reset", int'(dead_valid), 0);
      check(mispredict_count == '0, "R1", "count after reset", int'(mispredict_count), 0);
   endtask

   task automatic t_untracked;
      do_fill(3, 'h333);
      watch(80);
      check(trig_cnt == 0, "R4", "never-evicted address triggers", trig_cnt, 0);
      do_evict(3);
      // same index (low 5 bits = 0x13), different tag
      do_fill(3, 'h353);
      watch(80);
      check(trig_cnt == 0, "R4", "aliasing tag triggers", trig_cnt, 0);
      do_evict(3);
   endtask

   task automatic t_learn;
      teach(5, 'h120, 10);
      do_fill(7, 'h120);
      watch(60);
      check(trig_cnt == 1, "R5", "triggers in one residency", trig_cnt, 1);
      check(trig_n[0] >= 22 && trig_n[0] <= 37, "R3", "trigger cycle (R2 lifetime 10)",
            trig_n[0], 22);
      check(trig_f[0] == 7, "R6", "dead_frame", trig_f[0], 7);
      check(trig_a[0] == 'h120, "R6", "dead_addr", trig_a[0], 'h120);
   endtask

   task automatic t_mispredict;
      do_access(7);
      check(mispredict_count == 1, "R7", "count after access to dead line",
            int'(mispredict_count), 1);
      do_access(7);
      check(mispredict_count == 1, "R7", "count after second access",
            int'(mispredict_count), 1);
   endtask

   task automatic t_rearm;
      do_fill(7, 'h120);
      watch(60);
      check(trig_cnt == 1, "R5", "trigger after refill", trig_cnt, 1);
      check(trig_n[0] >= 22 && trig_n[0] <= 37, "R3", "refill trigger cycle",
            trig_n[0], 22);
      do_evict(7);
   endtask

   task automatic t_live_access;
      teach(2, 'h0A0, 30);
      do_fill(2, 'h0A0);
      watch(20);
      do_access(2);
      check(trig_cnt == 0, "R3", "trigger before deadline", trig_cnt, 0);
      check(mispredict_count == 1, "R8", "count after live access",
            int'(mispredict_count), 1);
      do_evict(2);
   endtask

   task automatic t_evict_early;
      teach(9, 'h0B0, 4);
      do_fill(9, 'h0B0);
      idle(3);
      do_evict(9);
      watch(40);
      check(trig_cnt == 0, "R9", "trigger after eviction", trig_cnt, 0);
   endtask

   task automatic t_two_frames;
      do_fill(1, 'h040); do_evict(1);
      do_fill(1, 'h041); do_evict(1);
      do_fill(1, 'h040);
      do_fill(2, 'h041);
      watch(40);
      check(trig_cnt == 2, "R10", "triggers for two dead lines", trig_cnt, 2);
      if (trig_cnt == 2) begin
         check(trig_n[0] != trig_n[1], "R10", "separate cycles", trig_n[1], trig_n[0] + 1);
         check((trig_f[0] == 1 && trig_a[0] == 'h040 && trig_f[1] == 2 && trig_a[1] == 'h041) ||
               (trig_f[0] == 2 && trig_a[0] == 'h041 && trig_f[1] == 1 && trig_a[1] == 'h040),
               "R10", "frames reported", trig_f[0] * 16 + trig_f[1], 1 * 16 + 2);
         check(trig_n[1] <= 17, "R10", "latest report within one scan", trig_n[1], 17);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_untracked();
      t_learn();
      t_mispredict();
      t_rearm();
      t_live_access();
      t_evict_early();
      t_two_frames();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule